// File: doc/BRIEF.md
# DDR SDRAM Bank Command Legality Monitor

This block sits passively on the command bus of a double-data-rate SDRAM with several banks. On every clock edge it decodes the command from chip-select, RAS, CAS and WE, together with the bank address and the auto-precharge address bit. It keeps one state machine per bank and one device-wide state machine. Several of these states are timed, and their lengths come from cycle counts given on input ports. The block judges each command against the current state of the bank it targets. For the few commands that are not bank-specific, it judges against the whole device.

A command that is not allowed raises a one-cycle error pulse with a reason code on the cycle after it was registered. The block does not act on that command. A legal command moves the targeted bank, or the whole device, to its next state.

The bank states are Idle, Opening, Open, Reading, Writing, Reading-with-autoclose, Writing-with-autoclose and Closing. Their transitions are:

- Idle goes to Opening on Activate.
- Opening goes to Open after tRCD.
- Open goes to Reading, Writing or an autoclose state on Read or Write, and to Closing on Precharge.
- Reading and Writing return to Open after BURST_LEN/2 cycles, or on Burst Terminate (Reading only).
- A Read or Write restarts a burst from Reading or Writing. Precharge truncates it into Closing.
- The autoclose states and Closing end in Idle.

The device-wide machine has three states. Free goes to Refreshing for tRFC cycles on Auto Refresh, and to Mode-Setting for tMRD cycles on Mode Register Set.

Top module: `ddr_cmd_guard`

## Requirements
- R1: A command is judged and acted upon only when CKE is high in both the current and the previous cycle; otherwise it raises no error and changes no state.
- R2: Deselect (cs_n=1, other pins ignored) and NOP (cs_n=0, ras_n/cas_n/we_n = 1,1,1) never raise an error in any state. Other encodings, with cs_n=0 and given as ras_n,cas_n,we_n, are: Activate 0,1,1; Read 1,0,1; Write 1,0,0; Precharge 0,1,0; Auto Refresh 0,0,1; Mode Register Set 0,0,0; Burst Terminate 1,1,0.
- R3: An Idle bank accepts only Activate, which makes it Opening for t_rcd cycles and then Open. Read, Write or single-bank Precharge to an Idle bank is rejected with code 3.
- R4: Auto Refresh and Mode Register Set need every bank Idle, else code 4. When accepted, the device is busy for t_rfc or t_mrd cycles, with all_idle_o low. Any non-NOP command in that time gets code 1, and afterwards all_idle_o is high again.
- R5: An Open bank accepts Read, Write and Precharge and rejects Activate (code 3). A burst without autoclose lasts BURST_LEN/2 cycles and then returns to Open. Precharge makes the bank Closing for t_rp cycles and then Idle.
- R6: A Reading bank accepts a new Read, Precharge (truncating the burst) and Burst Terminate; Write or Activate to it gets code 3.
- R7: A Writing bank accepts Read, a new Write and Precharge (truncating the burst); Activate to it gets code 3.
- R8: While a bank is Opening, Closing or in an autoclose state, any Activate, Read, Write or Precharge to it gets code 2; other banks remain usable.
- R9: Read or Write with the auto-precharge bit high puts the bank in Reading-with-autoclose or Writing-with-autoclose for BURST_LEN/2 + t_rp cycles, after which it is Idle.
- R10: Precharge with the auto-precharge bit high closes all banks. It is accepted only when no bank is Opening, Closing or autoclosing, else code 2. When accepted, every bank is Closing for t_rp cycles and then Idle.
- R11: Burst Terminate acts on the bank that received the most recent Read, whatever ba says. It is accepted only if that bank is Reading, which returns it to Open; otherwise it gets code 5.
- R12: A rejected command gives err_o high with its code for exactly the cycle after it was registered, and leaves all bank states as the timers alone would make them. A legal command gives err_o low and code 0.
- R13: bank_state_o bits [3b+2:3b] hold bank b's state: 0 Idle, 1 Opening, 2 Open, 3 Reading, 4 Writing, 5 Reading-with-autoclose, 6 Writing-with-autoclose, 7 Closing. After reset all are 0, all_idle_o is 1 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| t_rcd | input | TIMER_W | Activate-to-access time, cycles |
| t_rp | input | TIMER_W | Precharge time, cycles |
| t_rfc | input | TIMER_W | Refresh time, cycles |
| t_mrd | input | TIMER_W | Mode register time, cycles |
| bank_state_o | output | 3*NUM_BANKS | Packed per-bank state codes |
| all_idle_o | output | 1 | All banks Idle and device not busy |
| err_o | output | 1 | Illegal-command pulse |
| err_code_o | output | 3 | Reason for the rejection |

## Verification
A bank machine in the wrong state is visible on bank_state_o on the very next cycle. It also shows up one cycle after the next command to that bank, as a spurious or missing error pulse. A timer that is off by one shows when a command issued exactly t cycles after its trigger is judged differently than expected. A wrong most-recent-read tracker is exposed by the first Burst Terminate after two interleaved reads to different banks.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE     = 3'd0,
        BK_OPENING  = 3'd1,
        BK_OPEN     = 3'd2,
        BK_READ     = 3'd3,
        BK_WRITE    = 3'd4,
        BK_READ_AC  = 3'd5,
        BK_WRITE_AC = 3'd6,
        BK_CLOSING  = 3'd7
    } bank_e;

    typedef enum logic [1:0] {
        GL_FREE,
        GL_REFRESH,
        GL_MODE
    } glob_e;

    typedef enum logic [2:0] {
        E_NONE        = 3'd0,
        E_GLOBAL_BUSY = 3'd1,
        E_BANK_BUSY   = 3'd2,
        E_WRONG_STATE = 3'd3,
        E_NEED_IDLE   = 3'd4,
        E_NO_BURST    = 3'd5
    } err_e;

    localparam int BANK_STATE_W = 3;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
                3'b110: cmd = CMD_BST;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_guard_pkg::*;
#(
    parameter int TIMER_W   = 6,
    parameter int BURST_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  cmd_e               cmd,
    input  logic               ap,
    input  logic               pall,
    input  logic               bst,
    input  logic [TIMER_W-1:0] t_rcd,
    input  logic [TIMER_W-1:0] t_rp,
    output bank_e              state
);

    localparam int CNT_W = TIMER_W + $clog2(BURST_CYC + 1) + 1;

    logic [CNT_W-1:0] cnt, cnt_nxt;
    bank_e            state_nxt;
    logic [CNT_W-1:0] rcd_ld, rp_ld, burst_ld, ac_ld;
    logic             expired;

    // A window of n cycles loads n-1; zero is treated as one cycle
    always_comb begin
        rcd_ld   = (t_rcd == '0) ? '0 : CNT_W'(t_rcd) - CNT_W'(1);
        rp_ld    = (t_rp == '0) ? '0 : CNT_W'(t_rp) - CNT_W'(1);
        burst_ld = CNT_W'(BURST_CYC - 1);
        ac_ld    = CNT_W'(BURST_CYC) + CNT_W'(t_rp) - CNT_W'(1);
        expired  = (cnt == '0);
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = expired ? '0 : cnt - CNT_W'(1);
        if (pall) begin
            state_nxt = BK_CLOSING;
            cnt_nxt   = rp_ld;
        end else if (bst) begin
            state_nxt = BK_OPEN;
            cnt_nxt   = '0;
        end else if (go) begin
            case (cmd)
                CMD_ACT: begin
                    state_nxt = BK_OPENING;
                    cnt_nxt   = rcd_ld;
                end
                CMD_RD: begin
                    state_nxt = ap ? BK_READ_AC : BK_READ;
                    cnt_nxt   = ap ? ac_ld : burst_ld;
                end
                CMD_WR: begin
                    state_nxt = ap ? BK_WRITE_AC : BK_WRITE;
                    cnt_nxt   = ap ? ac_ld : burst_ld;
                end
                CMD_PRE: begin
                    state_nxt = BK_CLOSING;
                    cnt_nxt   = rp_ld;
                end
                default: ;
            endcase
        end else begin
            unique case (state)
                BK_IDLE, BK_OPEN: ;
                BK_OPENING, BK_READ, BK_WRITE:
                    if (expired) state_nxt = BK_OPEN;
                BK_READ_AC, BK_WRITE_AC, BK_CLOSING:
                    if (expired) state_nxt = BK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ddr_global_fsm.sv
module ddr_global_fsm
    import ddr_guard_pkg::*;
#(
    parameter int TIMER_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_ref,
    input  logic               go_mrs,
    input  logic [TIMER_W-1:0] t_rfc,
    input  logic [TIMER_W-1:0] t_mrd,
    output glob_e              state
);

    logic [TIMER_W-1:0] cnt, cnt_nxt;
    glob_e              state_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = (cnt == '0) ? '0 : cnt - TIMER_W'(1);
        unique case (state)
            GL_FREE: begin
                if (go_ref) begin
                    state_nxt = GL_REFRESH;
                    cnt_nxt   = (t_rfc == '0) ? '0 : t_rfc - TIMER_W'(1);
                end else if (go_mrs) begin
                    state_nxt = GL_MODE;
                    cnt_nxt   = (t_mrd == '0) ? '0 : t_mrd - TIMER_W'(1);
                end
            end
            GL_REFRESH, GL_MODE:
                if (cnt == '0) state_nxt = GL_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GL_FREE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    input  bank_e           st [NUM_BANKS],
    input  logic            dev_busy,
    input  logic [BA_W-1:0] last_rd,
    input  logic            last_rd_vld,
    output logic            banks_idle,
    output err_e            code
);

    logic  pall_ok;
    bank_e tgt;

    always_comb begin
        banks_idle = 1'b1;
        pall_ok    = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BK_IDLE) banks_idle = 1'b0;
            if (!(st[b] inside {BK_IDLE, BK_OPEN, BK_READ, BK_WRITE})) pall_ok = 1'b0;
        end
        tgt = st[ba];
    end

    always_comb begin
        code = E_NONE;
        if (cmd inside {CMD_DESEL, CMD_NOP}) begin
            code = E_NONE;
        end else if (dev_busy) begin
            code = E_GLOBAL_BUSY;
        end else if (cmd inside {CMD_REF, CMD_MRS}) begin
            if (!banks_idle) code = E_NEED_IDLE;
        end else if (cmd == CMD_BST) begin
            if (!(last_rd_vld && st[last_rd] == BK_READ)) code = E_NO_BURST;
        end else if (cmd == CMD_PRE && ap) begin
            if (!pall_ok) code = E_BANK_BUSY;
        end else begin
            unique case (tgt)
                BK_OPENING, BK_READ_AC, BK_WRITE_AC, BK_CLOSING:
                    code = E_BANK_BUSY;
                BK_IDLE:
                    if (cmd != CMD_ACT) code = E_WRONG_STATE;
                BK_OPEN, BK_WRITE:
                    if (cmd == CMD_ACT) code = E_WRONG_STATE;
                BK_READ:
                    if (cmd inside {CMD_ACT, CMD_WR}) code = E_WRONG_STATE;
            endcase
        end
    end

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TIMER_W   = 6,
    parameter int BURST_LEN = 8,
    parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cke,
    input  logic                              cs_n,
    input  logic                              ras_n,
    input  logic                              cas_n,
    input  logic                              we_n,
    input  logic [BA_W-1:0]                   ba,
    input  logic                              ap,
    input  logic [TIMER_W-1:0]                t_rcd,
    input  logic [TIMER_W-1:0]                t_rp,
    input  logic [TIMER_W-1:0]                t_rfc,
    input  logic [TIMER_W-1:0]                t_mrd,
    output logic [NUM_BANKS*BANK_STATE_W-1:0] bank_state_o,
    output logic                              all_idle_o,
    output logic                              err_o,
    output logic [2:0]                        err_code_o
);

    localparam int BURST_CYC = (BURST_LEN / 2 > 0) ? BURST_LEN / 2 : 1;

    cmd_e            cmd;
    bank_e           bank_st [NUM_BANKS];
    glob_e           dev_st;
    err_e            code;
    logic            banks_idle;
    logic            cke_q;
    logic            judged;
    logic            accept;
    logic [BA_W-1:0] last_rd;
    logic            last_rd_vld;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_cmd_judge #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W)
    ) u_judge (
        .cmd         (cmd),
        .ba          (ba),
        .ap          (ap),
        .st          (bank_st),
        .dev_busy    (dev_st != GL_FREE),
        .last_rd     (last_rd),
        .last_rd_vld (last_rd_vld),
        .banks_idle  (banks_idle),
        .code        (code)
    );

    assign judged = cke & cke_q;
    assign accept = judged && (code == E_NONE) && !(cmd inside {CMD_DESEL, CMD_NOP});

    ddr_global_fsm #(
        .TIMER_W (TIMER_W)
    ) u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_ref (accept && cmd == CMD_REF),
        .go_mrs (accept && cmd == CMD_MRS),
        .t_rfc  (t_rfc),
        .t_mrd  (t_mrd),
        .state  (dev_st)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(g));

        ddr_bank_fsm #(
            .TIMER_W   (TIMER_W),
            .BURST_CYC (BURST_CYC)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (accept && hit && ((cmd inside {CMD_ACT, CMD_RD, CMD_WR}) || (cmd == CMD_PRE && !ap))),
            .cmd   (cmd),
            .ap    (ap),
            .pall  (accept && cmd == CMD_PRE && ap),
            .bst   (accept && cmd == CMD_BST && last_rd == BA_W'(g)),
            .t_rcd (t_rcd),
            .t_rp  (t_rp),
            .state (bank_st[g])
        );

        assign bank_state_o[g*BANK_STATE_W +: BANK_STATE_W] = bank_st[g];
    end

    assign all_idle_o = banks_idle && (dev_st == GL_FREE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q       <= 1'b0;
            last_rd     <= '0;
            last_rd_vld <= 1'b0;
            err_o       <= 1'b0;
            err_code_o  <= E_NONE;
        end else begin
            cke_q      <= cke;
            err_o      <= judged && (code != E_NONE);
            err_code_o <= judged ? code : E_NONE;
            if (accept && cmd == CMD_RD) begin
                last_rd     <= ba;
                last_rd_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BA_W-1:0]        ba,
    input logic [NUM_BANKS*3-1:0] bank_state_o,
    input logic                   all_idle_o,
    input logic                   err_o,
    input logic [2:0]             err_code_o
);

    logic       cke_seen;
    logic       live;
    logic [2:0] pins;
    logic [2:0] s0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_seen <= 1'b0;
        else        cke_seen <= cke;
    end

    assign live = cke && cke_seen && !cs_n;
    assign pins = {ras_n, cas_n, we_n};
    assign s0   = bank_state_o[2:0];

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || pins == 3'b111) |=> !err_o); // R2

    AST_CKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke || !cke_seen) |=> !err_o); // R1

    AST_IDLE_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && pins == 3'b011 && ba == '0 && all_idle_o) |=> (s0 == 3'd1 && !err_o)); // R3

    AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && pins == 3'b001 && !all_idle_o) |=> (err_o && err_code_o != 3'd0)); // R4

    AST_OPENING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ba == '0 && s0 == 3'd1 && (pins inside {3'b011, 3'b101, 3'b100}))
            |=> (err_o && err_code_o == 3'd2)); // R8

    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> err_code_o != 3'd0); // R12

endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .bank_state_o (bank_state_o),
    .all_idle_o   (all_idle_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/ddr_cmd_guard_test.sv
module ddr_cmd_guard_test;

    localparam logic [2:0] P_ACT = 3'b011;
    localparam logic [2:0] P_RD  = 3'b101;
    localparam logic [2:0] P_WR  = 3'b100;
    localparam logic [2:0] P_PRE = 3'b010;
    localparam logic [2:0] P_REF = 3'b001;
    localparam logic [2:0] P_MRS = 3'b000;
    localparam logic [2:0] P_BST = 3'b110;
    localparam logic [2:0] P_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        ap = 1'b0;
    logic [5:0]  t_rcd = 6'd3, t_rp = 6'd3, t_rfc = 6'd6, t_mrd = 6'd2;
    logic [11:0] bank_state_o;
    logic        all_idle_o, err_o;
    logic [2:0]  err_code_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    ddr_cmd_guard #(.NUM_BANKS(4), .TIMER_W(6), .BURST_LEN(8)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .t_rcd(t_rcd),
        .t_rp(t_rp), .t_rfc(t_rfc), .t_mrd(t_mrd), .bank_state_o(bank_state_o),
        .all_idle_o(all_idle_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    function automatic int st(input int b);
        return int'(bank_state_o[b*3 +: 3]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [2:0] p, input int b, input logic a, input logic k);
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = p; ba = 2'(b); ap = a; cke = k;
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] p, input int b, input logic a);
        drive(1'b0, p, b, a, 1'b1);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, P_NOP, 0, 1'b0, 1'b1);
    endtask

    task automatic ok(input string tag);
        check({tag, " err"}, int'(err_o), 0);
    endtask

    task automatic bad(input string tag, input int code);
        check({tag, " err"}, int'(err_o), 1);
        check({tag, " code"}, int'(err_code_o), code);
    endtask

    task automatic open_row(input int b);
        issue(P_ACT, b, 1'b0);
        nop(3);
        check("R3 open_row", st(b), 2);
    endtask

    task automatic t_reset;
        check("R13 reset states", int'(bank_state_o), 0);
        check("R13 reset all_idle", int'(all_idle_o), 1);
        check("R13 reset err", int'(err_o), 0);
    endtask

    task automatic t_cke;
        drive(1'b0, P_RD, 0, 1'b0, 1'b0);
        ok("R1 cke low");
        drive(1'b0, P_RD, 0, 1'b0, 1'b1);
        ok("R1 cke was low");
        check("R1 state kept", st(0), 0);
        issue(P_RD, 0, 1'b0);
        bad("R3 read on idle", 3);
        nop(1);
        ok("R12 pulse ends");
    endtask

    task automatic t_nop;
        drive(1'b1, P_MRS, 0, 1'b0, 1'b1);
        ok("R2 deselect");
        nop(1);
        ok("R2 nop");
        check("R2 all_idle", int'(all_idle_o), 1);
    endtask

    task automatic t_act;
        issue(P_ACT, 0, 1'b0);
        ok("R3 act");
        check("R3 opening", st(0), 1);
        nop(2);
        check("R3 still opening", st(0), 1);
        nop(1);
        check("R3 open after trcd", st(0), 2);
        issue(P_ACT, 0, 1'b0);
        bad("R5 act on open", 3);
        check("R12 state kept", st(0), 2);
        issue(P_RD, 0, 1'b0);
        ok("R5 read");
        nop(3);
        check("R5 reading", st(0), 3);
        nop(1);
        check("R5 burst end", st(0), 2);
        issue(P_PRE, 0, 1'b0);
        ok("R5 pre");
        nop(2);
        check("R5 closing", st(0), 7);
        nop(1);
        check("R5 idle after trp", st(0), 0);
    endtask

    task automatic t_busy;
        issue(P_ACT, 1, 1'b0);
        issue(P_RD, 1, 1'b0);
        bad("R8 read while opening", 2);
        check("R8 state kept", st(1), 1);
        issue(P_ACT, 2, 1'b0);
        ok("R8 other bank");
        issue(P_PRE, 0, 1'b1);
        bad("R10 pall blocked", 2);
        check("R10 b1 open", st(1), 2);
        nop(2);
        check("R10 b2 open", st(2), 2);
        issue(P_PRE, 0, 1'b1);
        ok("R10 pall");
        check("R10 all closing", int'(bank_state_o), 12'hFFF);
        check("R10 all_idle low", int'(all_idle_o), 0);
        issue(P_ACT, 3, 1'b0);
        bad("R10 act while closing", 2);
        nop(1);
        check("R10 still closing", st(3), 7);
        nop(1);
        check("R10 all idle", int'(bank_state_o), 0);
        check("R10 all_idle", int'(all_idle_o), 1);
    endtask

    task automatic t_ref;
        issue(P_REF, 0, 1'b0);
        ok("R4 ref");
        issue(P_ACT, 0, 1'b0);
        bad("R4 act during ref", 1);
        nop(4);
        check("R4 busy", int'(all_idle_o), 0);
        nop(1);
        check("R4 free after trfc", int'(all_idle_o), 1);
        issue(P_MRS, 0, 1'b0);
        ok("R4 mrs");
        issue(P_MRS, 0, 1'b0);
        bad("R4 mrs during mrs", 1);
        nop(1);
        check("R4 free after tmrd", int'(all_idle_o), 1);
        issue(P_ACT, 0, 1'b0);
        issue(P_MRS, 0, 1'b0);
        bad("R4 mrs with bank busy", 4);
        nop(2);
        issue(P_PRE, 0, 1'b0);
        nop(3);
        check("R4 cleanup", int'(all_idle_o), 1);
    endtask

    task automatic t_write;
        open_row(0);
        issue(P_WR, 0, 1'b0);
        ok("R5 write");
        check("R5 writing", st(0), 4);
        issue(P_ACT, 0, 1'b0);
        bad("R7 act while writing", 3);
        issue(P_RD, 0, 1'b0);
        ok("R7 read from write");
        check("R7 reading", st(0), 3);
        issue(P_WR, 0, 1'b0);
        bad("R6 write while reading", 3);
        issue(P_PRE, 0, 1'b0);
        ok("R6 pre truncates");
        check("R6 closing", st(0), 7);
        nop(3);
        check("R6 idle", st(0), 0);
        open_row(0);
        issue(P_WR, 0, 1'b0);
        issue(P_WR, 0, 1'b0);
        ok("R7 write restarts");
        nop(3);
        check("R7 still writing", st(0), 4);
        issue(P_PRE, 0, 1'b0);
        ok("R7 pre truncates");
        nop(3);
    endtask

    task automatic t_ap;
        open_row(1);
        issue(P_RD, 1, 1'b1);
        ok("R9 read ac");
        check("R9 read ac state", st(1), 5);
        issue(P_RD, 1, 1'b0);
        bad("R8 read during ac", 2);
        issue(P_BST, 0, 1'b0);
        bad("R11 bst after ac read", 5);
        nop(4);
        check("R9 still autoclosing", st(1), 5);
        nop(1);
        check("R9 idle after burst+trp", st(1), 0);
        open_row(2);
        issue(P_WR, 2, 1'b1);
        check("R9 write ac state", st(2), 6);
        nop(6);
        check("R9 write ac hold", st(2), 6);
        nop(1);
        check("R9 write ac idle", st(2), 0);
    endtask

    task automatic t_bst;
        open_row(0);
        open_row(1);
        issue(P_RD, 0, 1'b0);
        issue(P_RD, 1, 1'b0);
        issue(P_BST, 0, 1'b0);
        ok("R11 bst");
        check("R11 last read bank open", st(1), 2);
        check("R11 other bank reading", st(0), 3);
        issue(P_BST, 0, 1'b0);
        bad("R11 bst no burst", 5);
        check("R11 b0 untouched", st(0), 3);
        nop(1);
        check("R6 b0 burst end", st(0), 2);
        issue(P_PRE, 0, 1'b1);
        ok("R10 pall from open");
        nop(3);
        check("R10 idle", int'(all_idle_o), 1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        nop(2);
        t_nop();
        t_cke();
        t_act();
        t_busy();
        t_ref();
        t_write();
        t_ap();
        t_bst();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule